// File: doc/BRIEF.md
# Machine-Cycle State Sequencer

This block is the timing-state engine of a small 8-bit processor. On every clock it selects one state. These are the reset state, the six normal bus states T1 to T6, a wait state, a hold state and a halt state. The choice depends on the kind of bus operation in progress and on a few handshake inputs. Decode logic outside the block supplies the cycle type and two flags. One flag says whether the current machine cycle is the last of its instruction, and the other says whether an opcode fetch needs the long six-state form. The block answers with a one-hot state vector and with strobes that mark where each machine cycle begins and ends.

The block also keeps four pieces of control state. The halt latch is set by a halt request in T4. The hold-acknowledge latch is set when HOLD is sampled high. The interrupt-enable latch is set by a pulse input. The interrupt-acknowledge flag is raised when an enabled, pending interrupt is accepted. Bus drivers, instruction decode and the datapath belong to other blocks.

Top module: `mcycle_seq`

## Requirements
- R1: A synchronous active-high reset puts the machine in the reset state (one-hot bit 0) and clears holdAck, intAck and intEnable. The first clock after reset moves it to T1 (bit 1). Exactly one state bit is ever high. The bit map is Tr=0, T1=1, T2=2, T3=3, T4=4, T5=5, T6=6, wait=7, hold=8, halt=9.
- R2: Every cycle type other than opcode fetch steps T1, T2, T3 and then T1. The cycle type codes are fetch=0, memory read=1, memory write=2, I/O read=3, I/O write=4, interrupt acknowledge=5 and bus idle=6.
- R3: An opcode fetch steps T1 to T4 and then to T1. When sixState is high it steps T1 to T6 and then to T1.
- R4: RDY is sampled in T2. When it is low the machine enters the wait state, and it stays there on every clock that RDY stays low. It moves to T3 on the clock that finds RDY high. RDY is ignored in every other state.
- R5: A bus-idle cycle goes from T2 to T3 whatever the level of RDY.
- R6: HOLD is sampled only in T2, in T4 of a six-state fetch, and in the halt state. A high sample sets holdAck. HOLD is not sampled in T1, T3, or T4 of a four-state fetch.
- R7: At the end of a cycle the checks run in a fixed order. If the cycle has further states, it continues. Otherwise, if holdAck is set, the machine enters the hold state. Otherwise it goes to T1. An interrupt is considered only when lastCycle is high and holdAck is clear.
- R8: The machine stays in the hold state while HOLD is high. On the clock that finds HOLD low it clears holdAck and goes to T1, or back to the halt state if the halt latch is set.
- R9: A pending interrupt with intEnable set is accepted at the end of a last cycle. On acceptance intAck is set and intEnable is cleared. intAck then clears at the end of the following machine cycle.
- R10: haltReq sets the halt latch only in T4. The next T1 then leads to the halt state instead of T2. haltReq in any other state has no effect.
- R11: The halt state is left for T1 only by an enabled, pending interrupt. That exit clears the halt latch, sets intAck and clears intEnable. HOLD in the halt state leads to the hold state and then back to the halt state.
- R12: A high intEnSet sets intEnable, unless an interrupt is accepted on the same clock.
- R13: cycleStart is high in T1 when the halt latch is clear. cycleEnd is high in the final state of a machine cycle: T3 of a non-fetch cycle, T4 of a short fetch, or T6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycleType | input | 3 | Kind of bus operation for the current machine cycle |
| lastCycle | input | 1 | Current machine cycle is the last of its instruction |
| sixState | input | 1 | Opcode fetch uses T5 and T6 |
| rdy | input | 1 | Addressed device is ready |
| hold | input | 1 | External bus request |
| haltReq | input | 1 | Halt instruction executing (acted on in T4) |
| intPending | input | 1 | An interrupt is requested |
| intEnSet | input | 1 | Set the interrupt-enable latch |
| stateOneHot | output | 10 | Current timing state, one-hot |
| holdAck | output | 1 | Hold-acknowledge latch |
| intAck | output | 1 | Interrupt-acknowledge flag |
| intEnable | output | 1 | Interrupt-enable latch |
| cycleStart | output | 1 | First state of a machine cycle |
| cycleEnd | output | 1 | Final state of a machine cycle |

## Verification
The assertions assume that every input is a known level on each rising edge and that cycleType is one of the seven legal codes. They sample cycleType in the state where it is used, so they do not require it to stay fixed across a cycle. Decode logic that is working keeps cycleType, lastCycle and sixState fixed for a whole machine cycle. The stimulus does the same, changes inputs only at falling edges, and uses only the legal codes.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  localparam int CTYPE_W = 3;
  localparam int NUM_STATES = 10;
  localparam int STATE_W = $clog2(NUM_STATES);

  typedef enum logic [CTYPE_W-1:0] {
    CT_FETCH  = 3'd0,
    CT_MEMRD  = 3'd1,
    CT_MEMWR  = 3'd2,
    CT_IORD   = 3'd3,
    CT_IOWR   = 3'd4,
    CT_INTACK = 3'd5,
    CT_IDLE   = 3'd6
  } cycleType_e;

  typedef enum logic [STATE_W-1:0] {
    S_RESET = 4'd0,
    S_T1    = 4'd1,
    S_T2    = 4'd2,
    S_T3    = 4'd3,
    S_T4    = 4'd4,
    S_T5    = 4'd5,
    S_T6    = 4'd6,
    S_WAIT  = 4'd7,
    S_HOLD  = 4'd8,
    S_HALT  = 4'd9
  } seqState_e;

  typedef struct packed {
    logic setHoldAck;
    logic clrHoldAck;
    logic setHalt;
    logic clrHalt;
    logic takeInt;
    logic cycleEnd;
  } seqStrobe_t;
endpackage

// File: rtl/mcseq_flags.sv
module mcseq_flags
  import mcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  input  logic       intEnSet,
  output logic       haltFlag,
  output logic       holdAckFlag,
  output logic       intEnFlag,
  output logic       intAckFlag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      haltFlag    <= 1'b0;
      holdAckFlag <= 1'b0;
      intEnFlag   <= 1'b0;
      intAckFlag  <= 1'b0;
    end else begin
      if (strobe.clrHalt)         haltFlag <= 1'b0;
      else if (strobe.setHalt)    haltFlag <= 1'b1;

      if (strobe.clrHoldAck)      holdAckFlag <= 1'b0;
      else if (strobe.setHoldAck) holdAckFlag <= 1'b1;

      if (strobe.takeInt)         intEnFlag <= 1'b0;
      else if (intEnSet)          intEnFlag <= 1'b1;

      if (strobe.takeInt)         intAckFlag <= 1'b1;
      else if (strobe.cycleEnd)   intAckFlag <= 1'b0;
    end
  end

  // R9: accepting an interrupt raises the acknowledge flag and drops the enable
  assert_int_take_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.takeInt |=> (intAckFlag && !intEnFlag));

  // R12: the enable latch rises only when an enable pulse is seen
  assert_inten_source_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(intEnFlag) |-> $past(intEnSet));
endmodule

// File: rtl/mcseq_ctrl.sv
module mcseq_ctrl
  import mcseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CTYPE_W-1:0] cycleType,
  input  logic               lastCycle,
  input  logic               sixState,
  input  logic               rdy,
  input  logic               hold,
  input  logic               haltReq,
  input  logic               intPending,
  input  logic               haltFlag,
  input  logic               holdAckFlag,
  input  logic               intEnFlag,
  output seqState_e          stateQ,
  output seqStrobe_t         strobe,
  output logic               cycleStart
);
  seqState_e stateNext;
  logic isFetch, isIdle, intReady, atEnd;

  assign isFetch  = (cycleType == CT_FETCH);
  assign isIdle   = (cycleType == CT_IDLE);
  assign intReady = intEnFlag && intPending;

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    atEnd     = 1'b0;
    case (stateQ)
      S_RESET: stateNext = S_T1;
      S_T1:    stateNext = haltFlag ? S_HALT : S_T2;
      S_T2: begin
        if (hold) strobe.setHoldAck = 1'b1;
        stateNext = (rdy || isIdle) ? S_T3 : S_WAIT;
      end
      S_WAIT:  if (rdy) stateNext = S_T3;
      S_T3: begin
        if (isFetch) stateNext = S_T4;
        else         atEnd = 1'b1;
      end
      S_T4: begin
        if (haltReq) strobe.setHalt = 1'b1;
        if (sixState) begin
          if (hold) strobe.setHoldAck = 1'b1;
          stateNext = S_T5;
        end else begin
          atEnd = 1'b1;
        end
      end
      S_T5:    stateNext = S_T6;
      S_T6:    atEnd = 1'b1;
      S_HOLD: begin
        if (!hold) begin
          strobe.clrHoldAck = 1'b1;
          stateNext = haltFlag ? S_HALT : S_T1;
        end
      end
      S_HALT: begin
        if (hold) begin
          strobe.setHoldAck = 1'b1;
          stateNext = S_HOLD;
        end else if (intReady) begin
          strobe.clrHalt = 1'b1;
          strobe.takeInt = 1'b1;
          stateNext = S_T1;
        end
      end
      default: stateNext = S_RESET;
    endcase

    if (atEnd) begin
      strobe.cycleEnd = 1'b1;
      if (holdAckFlag) begin
        stateNext = S_HOLD;
      end else begin
        stateNext = S_T1;
        if (lastCycle && intReady) strobe.takeInt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= S_RESET;
    else     stateQ <= stateNext;
  end

  assign cycleStart = (stateQ == S_T1) && !haltFlag;

  assert_reset_exit_R1: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_RESET) |=> (stateQ == S_T1));

  assert_short_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_T3 && !isFetch && !holdAckFlag) |=> (stateQ == S_T1));

  assert_wait_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_T2 && !rdy && !isIdle) |=> (stateQ == S_WAIT));

  assert_idle_nowait_R5: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_T2 && isIdle) |=> (stateQ == S_T3));

  assert_hold_stay_R8: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_HOLD && hold) |=> (stateQ == S_HOLD));

  assert_halt_set_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(haltFlag) |-> ($past(stateQ) == S_T4));

  assert_halt_stay_R11: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_HALT && !hold && !intReady) |=> (stateQ == S_HALT));
endmodule

// File: rtl/mcycle_seq.sv
module mcycle_seq
  import mcseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CTYPE_W-1:0]    cycleType,
  input  logic                  lastCycle,
  input  logic                  sixState,
  input  logic                  rdy,
  input  logic                  hold,
  input  logic                  haltReq,
  input  logic                  intPending,
  input  logic                  intEnSet,
  output logic [NUM_STATES-1:0] stateOneHot,
  output logic                  holdAck,
  output logic                  intAck,
  output logic                  intEnable,
  output logic                  cycleStart,
  output logic                  cycleEnd
);
  seqState_e  stateQ;
  seqStrobe_t strobe;
  logic haltFlag, holdAckFlag, intEnFlag, intAckFlag;

  mcseq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cycleType(cycleType), .lastCycle(lastCycle),
    .sixState(sixState), .rdy(rdy), .hold(hold), .haltReq(haltReq),
    .intPending(intPending), .haltFlag(haltFlag), .holdAckFlag(holdAckFlag),
    .intEnFlag(intEnFlag), .stateQ(stateQ), .strobe(strobe),
    .cycleStart(cycleStart)
  );

  mcseq_flags u_flags (
    .clk(clk), .rst(rst), .strobe(strobe), .intEnSet(intEnSet),
    .haltFlag(haltFlag), .holdAckFlag(holdAckFlag),
    .intEnFlag(intEnFlag), .intAckFlag(intAckFlag)
  );

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_onehot
    assign stateOneHot[g] = (stateQ == STATE_W'(g));
  end

  assign holdAck   = holdAckFlag;
  assign intAck    = intAckFlag;
  assign intEnable = intEnFlag;
  assign cycleEnd  = strobe.cycleEnd;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(stateOneHot) == 1);

  // R13: a cycle end is never reported in the same state as a cycle start
  assert_start_end_R13: assert property (@(posedge clk) disable iff (rst)
    !(cycleStart && cycleEnd));
endmodule

// File: tb/mcycle_seq_tb.sv
module mcycle_seq_tb;
  import mcseq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CTYPE_W-1:0] cycleType = '0;
  logic lastCycle = 0, sixState = 0, rdy = 1, hold = 0;
  logic haltReq = 0, intPending = 0, intEnSet = 0;
  logic [NUM_STATES-1:0] stateOneHot;
  logic holdAck, intAck, intEnable, cycleStart, cycleEnd;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mcycle_seq u_dut (
    .clk(clk), .rst(rst), .cycleType(cycleType), .lastCycle(lastCycle),
    .sixState(sixState), .rdy(rdy), .hold(hold), .haltReq(haltReq),
    .intPending(intPending), .intEnSet(intEnSet), .stateOneHot(stateOneHot),
    .holdAck(holdAck), .intAck(intAck), .intEnable(intEnable),
    .cycleStart(cycleStart), .cycleEnd(cycleEnd)
  );

  // fields: type[11:9] last[8] six[7] rdy[6] hold[5] expState[4:1] expHoldAck[0]
  localparam int NVEC = 41;
  localparam logic [11:0] VEC [NVEC] = '{
    {3'd1,4'b1010,4'd1,1'b0}, {3'd1,4'b1010,4'd2,1'b0},
    {3'd1,4'b1010,4'd3,1'b0}, {3'd1,4'b1010,4'd1,1'b0},
    {3'd0,4'b0010,4'd2,1'b0}, {3'd0,4'b0010,4'd3,1'b0},
    {3'd0,4'b0010,4'd4,1'b0}, {3'd0,4'b0010,4'd1,1'b0},
    {3'd0,4'b0110,4'd2,1'b0}, {3'd0,4'b0110,4'd3,1'b0},
    {3'd0,4'b0110,4'd4,1'b0}, {3'd0,4'b0110,4'd5,1'b0},
    {3'd0,4'b0110,4'd6,1'b0}, {3'd0,4'b0110,4'd1,1'b0},
    {3'd2,4'b0000,4'd2,1'b0}, {3'd2,4'b0000,4'd7,1'b0},
    {3'd2,4'b0000,4'd7,1'b0}, {3'd2,4'b0010,4'd3,1'b0},
    {3'd2,4'b0010,4'd1,1'b0},
    {3'd6,4'b0000,4'd2,1'b0}, {3'd6,4'b0000,4'd3,1'b0},
    {3'd6,4'b0000,4'd1,1'b0},
    {3'd3,4'b0011,4'd2,1'b0}, {3'd3,4'b0010,4'd3,1'b0},
    {3'd3,4'b0011,4'd1,1'b0},
    {3'd3,4'b1011,4'd2,1'b0}, {3'd3,4'b1011,4'd3,1'b1},
    {3'd3,4'b1011,4'd8,1'b1}, {3'd3,4'b1011,4'd8,1'b1},
    {3'd3,4'b1010,4'd1,1'b0},
    {3'd0,4'b1110,4'd2,1'b0}, {3'd0,4'b1110,4'd3,1'b0},
    {3'd0,4'b1110,4'd4,1'b0}, {3'd0,4'b1111,4'd5,1'b1},
    {3'd0,4'b1110,4'd6,1'b1}, {3'd0,4'b1110,4'd8,1'b1},
    {3'd0,4'b1110,4'd1,1'b0},
    {3'd0,4'b0010,4'd2,1'b0}, {3'd0,4'b0010,4'd3,1'b0},
    {3'd0,4'b0010,4'd4,1'b0}, {3'd0,4'b0011,4'd1,1'b0}
  };

  function automatic string vecTag(int i);
    if (i < 4)  return "R2";
    if (i < 14) return "R3";
    if (i < 19) return "R4";
    if (i < 22) return "R5";
    if (i < 25) return "R6";
    if (i < 30) return "R7/R8";
    if (i < 37) return "R6/R7";
    return "R6";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [CTYPE_W-1:0] t, logic l, logic s, logic r,
                       logic h, logic hq, logic ip, logic ies);
    cycleType = t; lastCycle = l; sixState = s; rdy = r;
    hold = h; haltReq = hq; intPending = ip; intEnSet = ies;
  endtask

  task automatic stepTo(string tag, int st);
    @(negedge clk);
    check(tag, 32'(stateOneHot), 32'(1) << st);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state in reset", 32'(stateOneHot), 32'h1);
    rst = 1'b0;
    check("R1 holdAck", 32'(holdAck), 0);
    check("R1 intAck", 32'(intAck), 0);
    check("R1 intEnable", 32'(intEnable), 0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][11:9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], 0, 0, 0);
      @(negedge clk);
      check(vecTag(i), 32'(stateOneHot), 32'(1) << VEC[i][4:1]);
      check(vecTag(i), 32'(holdAck), 32'(VEC[i][0]));
    end

    // R12 / R7 / R9 / R13: interrupt acceptance (state T1 here)
    check("R13 start in T1", 32'(cycleStart), 1);
    drive(CT_MEMRD, 0, 0, 1, 0, 0, 0, 1);
    stepTo("R2", 2);
    check("R12 enable set", 32'(intEnable), 1);
    check("R13 no start in T2", 32'(cycleStart), 0);
    check("R13 no end in T2", 32'(cycleEnd), 0);
    drive(CT_MEMRD, 0, 0, 1, 0, 0, 1, 0);
    stepTo("R2", 3);
    check("R13 end in T3", 32'(cycleEnd), 1);
    stepTo("R7 not last", 1);
    check("R7 no accept when not last", 32'(intAck), 0);
    check("R7 enable kept", 32'(intEnable), 1);
    drive(CT_MEMRD, 1, 0, 1, 0, 0, 1, 0);
    stepTo("R9", 2);
    stepTo("R9", 3);
    stepTo("R9", 1);
    check("R9 intAck set", 32'(intAck), 1);
    check("R9 enable cleared", 32'(intEnable), 0);
    stepTo("R9", 2);
    check("R9 intAck held", 32'(intAck), 1);
    stepTo("R9", 3);
    stepTo("R9", 1);
    check("R9 intAck cleared", 32'(intAck), 0);

    // R10: halt request outside T4 ignored
    drive(CT_MEMRD, 1, 0, 1, 0, 1, 0, 0);
    stepTo("R10", 2);
    stepTo("R10", 3);
    stepTo("R10", 1);
    stepTo("R10 ignored outside T4", 2);
    stepTo("R10", 3);
    stepTo("R10", 1);
    drive(CT_FETCH, 1, 0, 1, 0, 0, 0, 0);
    stepTo("R10", 2);
    stepTo("R10", 3);
    stepTo("R10", 4);
    drive(CT_FETCH, 1, 0, 1, 0, 1, 0, 0);
    stepTo("R10 T4 halt", 1);
    drive(CT_FETCH, 1, 0, 1, 0, 0, 1, 0);
    check("R13 no start when halted", 32'(cycleStart), 0);
    stepTo("R10 enter halt", 9);

    // R11: halt exit rules
    stepTo("R11 stay, int disabled", 9);
    stepTo("R11 stay, int disabled", 9);
    drive(CT_FETCH, 1, 0, 1, 1, 0, 0, 0);
    stepTo("R11 hold from halt", 8);
    check("R11 holdAck", 32'(holdAck), 1);
    stepTo("R11 hold stays", 8);
    drive(CT_FETCH, 1, 0, 1, 0, 0, 0, 1);
    stepTo("R11 back to halt", 9);
    check("R11 holdAck cleared", 32'(holdAck), 0);
    drive(CT_FETCH, 1, 0, 1, 0, 0, 0, 0);
    stepTo("R11 stay, none pending", 9);
    check("R12 enable set in halt", 32'(intEnable), 1);
    drive(CT_FETCH, 1, 0, 1, 0, 0, 1, 0);
    stepTo("R11 interrupt exit", 1);
    check("R11 intAck", 32'(intAck), 1);
    check("R11 enable cleared", 32'(intEnable), 0);
    drive(CT_FETCH, 1, 0, 1, 0, 0, 0, 0);
    stepTo("R11 halt latch cleared", 2);

    // R1: reset mid-cycle
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 32'(stateOneHot), 32'h1);
    stepTo("R1 to T1", 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule